// File: doc/BRIEF.md
# Vector Structure Interleave Permuter

This block reorders data elements across a group of two, three or four 64-bit vector registers. It is used beside a structure load/store path. After a load of array-of-structures data, the deinterleave mode scatters consecutive elements into successive registers. Before a structure store, the interleave mode gathers them back into one sequential stream. The two mappings are exact inverses of each other. The element width is chosen per operation: 8, 16, 32 or 64 bits.

Each operation arrives as one flat group of eight 32-bit words, together with a register count, an element-size code and a mode bit. The permuted group appears on a registered output one cycle later. The block has no storage beyond that output register and no flow control.

Top module: `vsip_permuter`

## Requirements
- R1: `out_valid` equals `in_valid` one cycle earlier, and it is 0 after reset. After reset `out_words` is all zero.
- R2: With `mode`=0 (deinterleave), register count n and E elements per register, element o of output register d equals input element o·n+d. Here input element i is the i-th element of the flat input.
- R3: With `mode`=1 (interleave), output element k·n+d equals element k of input register d.
- R4: Register d occupies word 2d (its low 32 bits) and word 2d+1 (its high 32 bits). Word w is bits [32w+31:32w] of the flat port. Element j of a register sits at bits [j·W+W-1 : j·W] of that register, where W is the element width.
- R5: `esize` code 0, 1, 2, 3 selects an element width of 8, 16, 32 or 64 bits respectively, so E = 64/W.
- R6: For a valid register count n, output words 2n and above are zero.
- R7: A `nregs` value outside 2..4 gives an all-zero `out_words`.
- R8: With 64-bit elements, both modes return every used input word unchanged.
- R9: For every register count and element size, feeding the interleave output into a deinterleave operation returns the original used words.
- R10: While `in_valid` is 0, `out_words` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 1 | 0 = deinterleave, 1 = interleave |
| nregs | input | 3 | Register count, 2 to 4 |
| esize | input | 2 | Element width code (8/16/32/64 bits) |
| in_words | input | 256 | Eight 32-bit source words, word 0 in the low bits |
| out_valid | output | 1 | Result present |
| out_words | output | 256 | Permuted words |

## Verification
The hardest case to reach from the ports is a three-register group with byte elements. There the division by three in the interleave index meets the largest element count, and the bytes that wrap across word halves are easy to misplace. Random stimulus cannot be relied on to cover this case often. A directed sweep therefore runs every register count and element size through interleave and then deinterleave. Random vectors covering all codes, including invalid counts, are added on top of that sweep.

// File: rtl/vsip_pkg.sv
package vsip_pkg;
    typedef enum logic {
        MODE_DEINT = 1'b0,
        MODE_INTER = 1'b1
    } vsip_mode_e;

    localparam int WORD_W     = 32;
    localparam int BYTES_WORD = WORD_W / 8;
    localparam int WORDS_REG  = 2;
endpackage

// File: rtl/vsip_src_index.sv
module vsip_src_index
    import vsip_pkg::*;
#(
    parameter int DST   = 0,
    parameter int IDX_W = 5
) (
    input  logic             mode_i,
    input  logic [2:0]       nregs_i,
    input  logic [1:0]       esz_i,
    output logic [IDX_W-1:0] src_o
);
    localparam int LW = 8;

    logic [LW-1:0] ed, be, eprl, o_off, d_reg, k_el, src_el, n_w, full;

    always_comb begin
        n_w   = LW'(nregs_i);
        ed    = LW'(DST) >> esz_i;
        be    = LW'(DST) & ((LW'(1) << esz_i) - LW'(1));
        eprl  = LW'(3) - LW'(esz_i);
        o_off = '0;
        d_reg = '0;
        k_el  = '0;
        if (vsip_mode_e'(mode_i) == MODE_DEINT) begin
            d_reg  = ed >> eprl;
            o_off  = ed & ((LW'(1) << eprl) - LW'(1));
            src_el = o_off * n_w + d_reg;
        end else begin
            case (nregs_i)
                3'd3: begin
                    k_el  = ed / LW'(3);
                    d_reg = ed - k_el * LW'(3);
                end
                3'd4: begin
                    k_el  = ed >> 2;
                    d_reg = ed & LW'(3);
                end
                default: begin
                    k_el  = ed >> 1;
                    d_reg = ed & LW'(1);
                end
            endcase
            src_el = (d_reg << eprl) + k_el;
        end
        full  = (src_el << esz_i) | be;
        src_o = full[IDX_W-1:0];
    end
endmodule

// File: rtl/vsip_byte_select.sv
module vsip_byte_select #(
    parameter int NBYTES = 32,
    parameter int IDX_W  = 5
) (
    input  logic [NBYTES*8-1:0]     data_i,
    input  logic [NBYTES*IDX_W-1:0] sel_i,
    input  logic [NBYTES-1:0]       keep_i,
    output logic [NBYTES*8-1:0]     data_o
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [IDX_W-1:0] idx;
        assign idx = sel_i[g*IDX_W +: IDX_W];
        assign data_o[g*8 +: 8] = keep_i[g] ? data_i[idx*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/vsip_permuter.sv
module vsip_permuter
    import vsip_pkg::*;
#(
    parameter int MAX_REGS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              mode,
    input  logic [2:0]                        nregs,
    input  logic [1:0]                        esize,
    input  logic [MAX_REGS*WORDS_REG*WORD_W-1:0] in_words,
    output logic                              out_valid,
    output logic [MAX_REGS*WORDS_REG*WORD_W-1:0] out_words
);
    localparam int NWORDS = MAX_REGS * WORDS_REG;
    localparam int NBYTES = NWORDS * BYTES_WORD;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int BPR    = WORDS_REG * BYTES_WORD;

    typedef struct packed {
        logic                valid;
        logic [NWORDS*WORD_W-1:0] words;
    } vsip_state_t;

    vsip_state_t state_d, state_q;

    logic                    cnt_ok;
    logic [NBYTES*IDX_W-1:0] sel;
    logic [NBYTES-1:0]       keep;
    logic [NBYTES*8-1:0]     permuted;

    assign cnt_ok = (nregs >= 3'd2) && (32'(nregs) <= MAX_REGS);

    for (genvar g = 0; g < NBYTES; g++) begin : g_idx
        vsip_src_index #(
            .DST   (g),
            .IDX_W (IDX_W)
        ) u_idx (
            .mode_i  (mode),
            .nregs_i (nregs),
            .esz_i   (esize),
            .src_o   (sel[g*IDX_W +: IDX_W])
        );
        assign keep[g] = cnt_ok && (g < 32'(nregs) * BPR);
    end

    vsip_byte_select #(
        .NBYTES (NBYTES),
        .IDX_W  (IDX_W)
    ) u_sel (
        .data_i (in_words),
        .sel_i  (sel),
        .keep_i (keep),
        .data_o (permuted)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.words = permuted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign out_words = state_q.words;
endmodule

// File: rtl/vsip_checker.sv
module vsip_checker #(
    parameter int NW = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    nregs,
    input logic [1:0]    esize,
    input logic [NW-1:0] in_words,
    input logic          out_valid,
    input logic [NW-1:0] out_words
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_words));
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nregs == 3'd2) |=> out_words[NW-1:NW/2] == '0);
    a_r7_bad_count: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (nregs < 3'd2 || nregs > 3'd4)) |=> out_words == '0);
    a_r8_wide_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && esize == 2'd3 && nregs == 3'd4) |=> out_words == $past(in_words));
endmodule

bind vsip_permuter vsip_checker #(.NW(MAX_REGS*2*32)) u_vsip_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .nregs     (nregs),
    .esize     (esize),
    .in_words  (in_words),
    .out_valid (out_valid),
    .out_words (out_words)
);

// File: tb/tb_vsip_permuter.sv
module tb_vsip_permuter;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          mode = 1'b0;
    logic [2:0]    nregs = 3'd2;
    logic [1:0]    esize = 2'd0;
    logic [NW-1:0] in_words = '0;
    logic          out_valid;
    logic [NW-1:0] out_words;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsip_permuter dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .nregs(nregs), .esize(esize), .in_words(in_words),
        .out_valid(out_valid), .out_words(out_words)
    );

    function automatic logic [NW-1:0] ref_perm(input logic md, input int n,
                                               input int ec, input logic [NW-1:0] src);
        logic [NW-1:0] res = '0;
        int ew  = 8 << ec;
        int epr = 64 / ew;
        int cnt = 0;
        if (n < 2 || n > 4) return '0;
        for (int a = 0; a < epr; a++) begin
            for (int d = 0; d < n; d++) begin
                int se, de;
                if (!md) begin de = d*epr + a; se = cnt; end
                else     begin de = cnt;       se = d*epr + a; end
                cnt++;
                for (int b = 0; b < ew; b++) res[de*ew + b] = src[se*ew + b];
            end
        end
        return res;
    endfunction

    function automatic logic [NW-1:0] used_mask(input int n);
        logic [NW-1:0] m = '0;
        for (int b = 0; b < n*64; b++) m[b] = 1'b1;
        return m;
    endfunction

    task automatic check(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic md, input int n, input int ec, input logic [NW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; mode = md; nregs = 3'(n); esize = 2'(ec); in_words = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [NW-1:0] rnd_data();
        logic [NW-1:0] r;
        for (int w = 0; w < 8; w++) r[w*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] d0, mid, back, seq;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        check("R1 reset valid", NW'(out_valid), '0);
        check("R1 reset words", out_words, '0);
        rst_n = 1'b1;

        for (int b = 0; b < 32; b++) seq[b*8 +: 8] = 8'(b);

        // R2 R4 R5: three registers, 8-bit elements, byte index pattern
        apply(1'b0, 3, 0, seq);
        check("R1 valid after op", NW'(out_valid), NW'(1));
        check("R2 deint 3x8", out_words, ref_perm(1'b0, 3, 0, seq));
        // directed R2 value: reg0 byte1 = source byte 3
        check("R2 R4 byte spot", NW'(out_words[15:8]), NW'(8'd3));
        apply(1'b1, 3, 0, seq);
        check("R3 inter 3x8", out_words, ref_perm(1'b1, 3, 0, seq));
        // R3 spot: output byte 1 = byte 0 of register 1 = source byte 8
        check("R3 R4 byte spot", NW'(out_words[15:8]), NW'(8'd8));
        apply(1'b0, 2, 1, seq);
        check("R5 deint 2x16", out_words, ref_perm(1'b0, 2, 1, seq));
        check("R6 upper zero n=2", out_words & ~used_mask(2), '0);

        // R10: idle cycles with changed inputs keep output
        mid = out_words;
        @(negedge clk);
        in_words = ~seq; mode = 1'b1; nregs = 3'd4;
        @(negedge clk);
        check("R10 hold", out_words, mid);
        check("R1 idle valid low", NW'(out_valid), '0);

        // R7: invalid counts
        for (int n = 0; n < 8; n++) begin
            if (n >= 2 && n <= 4) continue;
            apply(1'(n & 1), n, n & 3, seq);
            check("R7 bad count zero", out_words, '0);
        end

        // R8: 64-bit elements identity
        for (int n = 2; n <= 4; n++) begin
            d0 = rnd_data();
            apply(1'b0, n, 3, d0);
            check("R8 deint 64", out_words, d0 & used_mask(n));
            apply(1'b1, n, 3, d0);
            check("R8 inter 64", out_words, d0 & used_mask(n));
        end

        // R9: round trip for every configuration
        for (int n = 2; n <= 4; n++) begin
            for (int ec = 0; ec < 4; ec++) begin
                d0 = rnd_data();
                apply(1'b1, n, ec, d0);
                mid = out_words;
                check("R3 sweep inter", mid, ref_perm(1'b1, n, ec, d0));
                check("R6 sweep upper", mid & ~used_mask(n), '0);
                apply(1'b0, n, ec, mid);
                back = out_words;
                check("R9 round trip", back, d0 & used_mask(n));
            end
        end

        // random mix, including invalid counts
        for (int i = 0; i < 300; i++) begin
            logic md;
            int n, ec;
            md = 1'($urandom % 2);
            n  = ($urandom % 8 < 7) ? 2 + int'($urandom % 3) : int'($urandom % 8);
            ec = int'($urandom % 4);
            d0 = rnd_data();
            apply(md, n, ec, d0);
            check(md ? "R3 random" : "R2 random", out_words, ref_perm(md, n, ec, d0));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule